// File: doc/BRIEF.md
# Register LIFO Stack with Full and Empty Flags

This block is a last-in, first-out store built from a small array of registers. A pointer register always addresses the current top item. Status outputs mark the stack as holding no items or as holding every slot. A push strobe stores one input word and a pop strobe returns the top word. Popped data appears on a registered output one cycle after the strobe.

The pointer is advanced before a write and retreated after a read. A push therefore lands one slot above the old top, so the first item goes to slot 1. When the pointer wraps to zero after a push, the array is full and slot 0 holds the last item. When the pointer reaches zero after a pop, the array is empty.

Some requests are refused: a push while full, a pop while empty, and a push and pop strobed in the same cycle. Each refused request raises an error pulse for one cycle. It leaves the pointer, the flags, the stored words and the read data unchanged.

Top module: `lifo_reg_stack`

## Requirements
- R1: After reset the pointer is 0, the empty flag is 1, the full flag is 0, the error output is 0 and the read data is 0.
- R2: An accepted push (push strobe high, pop strobe low, full flag low) raises the pointer by one, modulo the depth, on the next clock edge. It stores the input word at the new pointer value, so the first push after reset lands at slot 1.
- R3: An accepted push that wraps the pointer to 0 sets the full flag, and that last item sits in slot 0. Every accepted push clears the empty flag.
- R4: An accepted pop (pop strobe high, push strobe low, empty flag low) puts the word stored at the current pointer on the read data output in the cycle after the strobe. It lowers the pointer by one, modulo the depth.
- R5: An accepted pop that brings the pointer to 0 sets the empty flag. Every accepted pop clears the full flag.
- R6: Words come back in the reverse order of their pushes, across a complete fill and drain and across any interleaving of pushes and pops.
- R7: A push while the full flag is 1 raises the error output for the following cycle. It leaves the pointer, the flags and the stored words unchanged.
- R8: A pop while the empty flag is 1 raises the error output for the following cycle. It leaves the pointer, the flags and the read data unchanged.
- R9: A push and a pop strobed in the same cycle raise the error output for the following cycle, and both are ignored.
- R10: The error output is 0 in the cycle after any accepted operation or idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| wr_data_i | input | DATA_W | Word to push |
| rd_data_o | output | DATA_W | Registered popped word |
| full_o | output | 1 | Every slot holds an item |
| empty_o | output | 1 | No item is held |
| err_o | output | 1 | One-cycle pulse after a refused request |
| sp_o | output | PTR_W | Pointer to the current top item |

## Verification
The bench builds the stack with a 3-bit pointer (eight slots) and 8-bit words. At that size, a complete fill to wraparound and a complete drain are short runs. The bench can also try every refusal case at both ends of the pointer range. A long interleaved sequence of pushes, pops, clashes and idle cycles passes through every pointer value many times. An arithmetic model in the bench checks each step.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_POP   = 2'b01,
        OP_PUSH  = 2'b10,
        OP_CLASH = 2'b11
    } lifo_op_e;

    typedef struct packed {
        logic full;
        logic empty;
        logic err;
    } lifo_flags_t;

endpackage

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
    import lifo_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_addr_o,
    output logic             rd_en_o,
    output logic [PTR_W-1:0] rd_addr_o,
    output logic [PTR_W-1:0] sp_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             err_o
);

    localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);
    localparam logic [PTR_W-1:0] PTR_ZERO = '0;

    typedef struct packed {
        logic [PTR_W-1:0] sp;
        lifo_flags_t      fl;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    lifo_op_e    op;
    logic [PTR_W-1:0] sp_up, sp_dn;

    assign op    = lifo_op_e'({push_i, pop_i});
    assign sp_up = st_q.sp + PTR_ONE;
    assign sp_dn = st_q.sp - PTR_ONE;

    always_comb begin
        st_d        = st_q;
        st_d.fl.err = 1'b0;
        wr_en_o     = 1'b0;
        rd_en_o     = 1'b0;
        wr_addr_o   = sp_up;
        rd_addr_o   = st_q.sp;
        unique case (op)
            OP_PUSH: begin
                if (st_q.fl.full) begin
                    st_d.fl.err = 1'b1;
                end else begin
                    wr_en_o       = 1'b1;
                    st_d.sp       = sp_up;
                    st_d.fl.full  = (sp_up == PTR_ZERO);
                    st_d.fl.empty = 1'b0;
                end
            end
            OP_POP: begin
                if (st_q.fl.empty) begin
                    st_d.fl.err = 1'b1;
                end else begin
                    rd_en_o       = 1'b1;
                    st_d.sp       = sp_dn;
                    st_d.fl.empty = (sp_dn == PTR_ZERO);
                    st_d.fl.full  = 1'b0;
                end
            end
            OP_CLASH: st_d.fl.err = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sp       <= PTR_ZERO;
            st_q.fl.full  <= 1'b0;
            st_q.fl.empty <= 1'b1;
            st_q.fl.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sp_o    = st_q.sp;
    assign full_o  = st_q.fl.full;
    assign empty_o = st_q.fl.empty;
    assign err_o   = st_q.fl.err;

    a_r2_push_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !st_q.fl.full) |=> (st_q.sp == $past(st_q.sp) + PTR_ONE));

    a_r4_pop_retreats: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !st_q.fl.empty) |=> (st_q.sp == $past(st_q.sp) - PTR_ONE));

    a_r3_full_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fl.full |-> (st_q.sp == PTR_ZERO));

    a_r5_empty_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fl.empty |-> (st_q.sp == PTR_ZERO && !st_q.fl.full));

    a_r7_err_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fl.err |-> ($stable(st_q.sp) && $stable(st_q.fl.full) && $stable(st_q.fl.empty)));

    a_r9_clash_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> st_q.fl.err);

    a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> !st_q.fl.err);

endmodule

// File: rtl/lifo_regfile.sv
module lifo_regfile #(
    parameter int PTR_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [PTR_W-1:0]  rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] word_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic hit;
        assign hit = wr_en_i && (wr_addr_i == PTR_W'(g));
        always_ff @(posedge clk) begin
            if (hit) begin
                word_q[g] <= wr_data_i;
            end
        end
    end

    assign rd_data_o = word_q[rd_addr_i];

endmodule

// File: rtl/lifo_reg_stack.sv
module lifo_reg_stack #(
    parameter int PTR_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              err_o,
    output logic [PTR_W-1:0]  sp_o
);

    logic              wr_en, rd_en;
    logic [PTR_W-1:0]  wr_addr, rd_addr;
    logic [DATA_W-1:0] rf_rdata;
    logic [DATA_W-1:0] rd_data_d, rd_data_q;

    lifo_ctrl #(.PTR_W(PTR_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push_i),
        .pop_i     (pop_i),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .rd_en_o   (rd_en),
        .rd_addr_o (rd_addr),
        .sp_o      (sp_o),
        .full_o    (full_o),
        .empty_o   (empty_o),
        .err_o     (err_o)
    );

    lifo_regfile #(.PTR_W(PTR_W), .DATA_W(DATA_W)) rf_i (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr),
        .rd_data_o (rf_rdata)
    );

    always_comb begin
        rd_data_d = rd_en ? rf_rdata : rd_data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else begin
            rd_data_q <= rd_data_d;
        end
    end

    assign rd_data_o = rd_data_q;

    a_r8_rd_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_i && !push_i) |=> $stable(rd_data_q));

    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));

endmodule

// File: tb/lifo_reg_stack_tb_top.sv
`timescale 1ns/1ps
module lifo_reg_stack_tb_top;

    localparam int PTR_W  = 3;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << PTR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_i = 1'b0;
    logic              pop_i = 1'b0;
    logic [DATA_W-1:0] wr_data_i = '0;
    logic [DATA_W-1:0] rd_data_o;
    logic              full_o, empty_o, err_o;
    logic [PTR_W-1:0]  sp_o;

    int n_checks = 0;
    int n_fail   = 0;

    int m_mem [DEPTH];
    int m_sp    = 0;
    int m_full  = 0;
    int m_empty = 1;
    int m_err   = 0;
    int m_rd    = 0;

    always #4 clk = ~clk;

    lifo_reg_stack #(.PTR_W(PTR_W), .DATA_W(DATA_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push_i),
        .pop_i     (pop_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .full_o    (full_o),
        .empty_o   (empty_o),
        .err_o     (err_o),
        .sp_o      (sp_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "sp",    int'(sp_o),      m_sp);
        chk(req, "full",  int'(full_o),    m_full);
        chk(req, "empty", int'(empty_o),   m_empty);
        chk(req, "err",   int'(err_o),     m_err);
        chk(req, "rd",    int'(rd_data_o), m_rd);
    endtask

    // Drives one cycle of strobes, advances the model, and checks the ports
    // after the edge that registers the result.
    task automatic step(input bit p, input bit q, input int d, input string req);
        bit bad;
        @(negedge clk);
        push_i = p;
        pop_i = q;
        wr_data_i = DATA_W'(d);
        bad = (p && q) || (p && m_full == 1) || (q && m_empty == 1);
        m_err = bad ? 1 : 0;
        if (!bad && p) begin
            m_sp = (m_sp + 1) % DEPTH;
            m_mem[m_sp] = d % 256;
            m_full = (m_sp == 0) ? 1 : 0;
            m_empty = 0;
        end else if (!bad && q) begin
            m_rd = m_mem[m_sp];
            m_sp = (m_sp + DEPTH - 1) % DEPTH;
            m_empty = (m_sp == 0) ? 1 : 0;
            m_full = 0;
        end
        @(negedge clk);
        push_i = 1'b0;
        pop_i = 1'b0;
        chk_all(req);
    endtask

    initial begin
        #(8ns * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1");

        // R2: first push at slot 1
        step(1, 0, 8'h11, "R2");
        chk("R2", "first sp", int'(sp_o), 1);
        for (int i = 1; i < DEPTH; i++) begin
            step(1, 0, 16 + i * 7, "R3");
        end
        chk("R3", "full after wrap", int'(full_o), 1);
        chk("R3", "sp wrapped", int'(sp_o), 0);

        // R7: refused push while full
        step(1, 0, 8'hEE, "R7");
        step(1, 0, 8'hDD, "R7");
        step(0, 0, 0, "R10");
        // R9: clash while full
        step(1, 1, 8'hCC, "R9");

        // R4 R6: drain in reverse order; last item from slot 0 first
        step(0, 1, 0, "R4");
        chk("R4", "slot0 word", int'(rd_data_o), 16 + (DEPTH - 1) * 7);
        for (int i = 1; i < DEPTH; i++) begin
            step(0, 1, 0, "R6");
        end
        chk("R5", "empty after drain", int'(empty_o), 1);
        chk("R6", "first word last", int'(rd_data_o), 8'h11);

        // R8: refused pop while empty
        step(0, 1, 0, "R8");
        step(0, 1, 0, "R8");
        step(1, 1, 8'h55, "R9");
        step(0, 0, 0, "R10");

        // interleaved sweep
        for (int i = 0; i < 600; i++) begin
            int sel;
            sel = (i * 5 + (i / 7) * 3) % 9;
            if (sel < 4)       step(1, 0, (i * 37 + 5) % 256, "R6");
            else if (sel < 7)  step(0, 1, 0, "R6");
            else if (sel == 7) step(1, 1, i % 256, "R9");
            else               step(0, 0, 0, "R10");
        end
        for (int i = 0; i < 3 * DEPTH; i++) begin
            step(1, 0, 200 + i, "R7");
        end
        for (int i = 0; i < 3 * DEPTH; i++) begin
            step(0, 1, 0, "R8");
        end

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule